// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a two-port memory and watches the accesses both ports make. The two highest word addresses of the memory serve as mailboxes, one for each direction of travel. When one port writes its outbound mailbox, the block lowers the active-low interrupt flag of the other port. When the receiving port reads that mailbox, its flag returns high.

The block does not store anything itself, and it does not hold the mailbox data. The mailbox words stay ordinary memory locations in the array beside it, and this block only decodes the control and address inputs of each port. Everything is sampled on a single clock. A flag changes on the clock edge that follows the access.

The mailbox locations follow the address width `ADDR_W`. The highest address (all ones) carries messages from left to right. The address one below it (all ones with bit 0 clear) carries messages from right to left.

Top module: `mbx_irq_flags`

## Requirements
- R1: While `rst_n` is low, both `l_int_n` and `r_int_n` are high (deasserted). They are also high on the first edge after reset is released, unless an access that sets a flag is sampled on that edge.
- R2: A left-port write sampled on a clock edge (`l_ce_n`=0, `l_rw`=0) to the highest address (all ones, 12'hFFF by default) drives `r_int_n` low after that edge. Output enable plays no part in a write.
- R3: A right-port read (`r_ce_n`=0, `r_rw`=1, `r_oe_n`=0) of the highest address drives `r_int_n` high after that edge, provided no left write to that address is sampled on the same edge.
- R4: A right-port write to the second-highest address (12'hFFE by default) drives `l_int_n` low after that edge.
- R5: A left-port read (`l_ce_n`=0, `l_rw`=1, `l_oe_n`=0) of the second-highest address drives `l_int_n` high after that edge, provided no right write to that address is sampled on the same edge.
- R6: When a set and a clear of the same flag are sampled on the same edge, the set wins and the flag ends up low.
- R7: Some accesses do not count: any access with chip enable high, and a read with output enable high. These neither set nor clear a flag.
- R8: A flag is not changed by accesses to any other address. It is also not changed by a port touching its own flag's mailbox the wrong way: a left read of the highest address, a right write of the highest address, a left write of the second-highest address, or a right read of the second-highest address.
- R9: With no qualifying set or clear, each flag holds its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which all accesses are sampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_ce_n | input | 1 | Left port chip enable, active low |
| l_rw | input | 1 | Left port direction: 1 = read, 0 = write |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | ADDR_W | Left port word address |
| r_ce_n | input | 1 | Right port chip enable, active low |
| r_rw | input | 1 | Right port direction: 1 = read, 0 = write |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | ADDR_W | Right port word address |
| l_int_n | output | 1 | Left port interrupt flag, active low |
| r_int_n | output | 1 | Right port interrupt flag, active low |

## Verification
The assertions assume that every control and address input is a known value from reset onward, and that each counts as one access for each edge on which it is sampled. The bench drives all inputs on the falling edge and holds the ports idle, with chip enables high, through reset and its release. The random phase picks addresses mostly from the two mailbox words and their immediate neighbours. It also picks each control bit on its own, so that reads without output enable, writes with output enable, and collisions between a set and a clear all occur often, while every input stays a legal 0 or 1.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Decoded mailbox activity of one port in one cycle.
   typedef struct packed {
      logic wr_top;   // qualified write to the highest word
      logic wr_nxt;   // qualified write to the second-highest word
      logic rd_top;   // qualified read of the highest word
      logic rd_nxt;   // qualified read of the second-highest word
   } mbx_hits_t;

   localparam int unsigned PORT_L = 0;
   localparam int unsigned PORT_R = 1;
   localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              ce_n,
   input  logic              rw,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   output mbx_hits_t         hits
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] NXT_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};

   logic is_wr;
   logic is_rd;
   logic at_top;
   logic at_nxt;

   // A write needs only chip enable; a read also needs output enable.
   assign is_wr  = !ce_n && !rw;
   assign is_rd  = !ce_n &&  rw && !oe_n;
   assign at_top = (addr == TOP_ADDR);
   assign at_nxt = (addr == NXT_ADDR);

   always_comb begin
      hits.wr_top = is_wr && at_top;
      hits.wr_nxt = is_wr && at_nxt;
      hits.rd_top = is_rd && at_top;
      hits.rd_nxt = is_rd && at_nxt;
   end

endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_n_o
);

   // Active-low flag kept directly in its output polarity; set wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_n_o <= 1'b1;
      end else if (set_i) begin
         flag_n_o <= 1'b0;
      end else if (clr_i) begin
         flag_n_o <= 1'b1;
      end
   end

endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_ce_n,
   input  logic              l_rw,
   input  logic              l_oe_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_ce_n,
   input  logic              r_rw,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_int_n,
   output logic              r_int_n
);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("mbx_irq_flags: ADDR_W must be at least 2");
      end
   endgenerate

   logic [NUM_PORTS-1:0]             ce_n_v;
   logic [NUM_PORTS-1:0]             rw_v;
   logic [NUM_PORTS-1:0]             oe_n_v;
   logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
   mbx_hits_t                        hits_v [NUM_PORTS];
   logic [NUM_PORTS-1:0]             flag_n_v;

   assign ce_n_v = {r_ce_n, l_ce_n};
   assign rw_v   = {r_rw,   l_rw};
   assign oe_n_v = {r_oe_n, l_oe_n};
   assign addr_v = {r_addr, l_addr};

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         localparam int unsigned OTHER = NUM_PORTS - 1 - p;
         logic set_w;
         logic clr_w;

         mbx_port_decode #(
            .ADDR_W (ADDR_W)
         ) u_dec (
            .ce_n (ce_n_v[p]),
            .rw   (rw_v[p]),
            .oe_n (oe_n_v[p]),
            .addr (addr_v[p]),
            .hits (hits_v[p])
         );

         if (p == PORT_L) begin : g_left
            // Inbound for the left port: second-highest word.
            assign set_w = hits_v[OTHER].wr_nxt;
            assign clr_w = hits_v[p].rd_nxt;
         end else begin : g_right
            // Inbound for the right port: highest word.
            assign set_w = hits_v[OTHER].wr_top;
            assign clr_w = hits_v[p].rd_top;
         end

         mbx_flag_cell u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_w),
            .clr_i    (clr_w),
            .flag_n_o (flag_n_v[p])
         );
      end
   endgenerate

   assign l_int_n = flag_n_v[PORT_L];
   assign r_int_n = flag_n_v[PORT_R];

endmodule

// File: rtl/mbx_irq_flags_chk.sv
module mbx_irq_flags_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_ce_n,
   input logic              l_rw,
   input logic              l_oe_n,
   input logic [ADDR_W-1:0] l_addr,
   input logic              r_ce_n,
   input logic              r_rw,
   input logic              r_oe_n,
   input logic [ADDR_W-1:0] r_addr,
   input logic              l_int_n,
   input logic              r_int_n
);

   localparam logic [ADDR_W-1:0] HI = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] LO = {{(ADDR_W-1){1'b1}}, 1'b0};

   logic lw_hi, rr_hi, rw_lo, lr_lo;
   assign lw_hi = !l_ce_n && !l_rw && (l_addr == HI);
   assign rr_hi = !r_ce_n &&  r_rw && !r_oe_n && (r_addr == HI);
   assign rw_lo = !r_ce_n && !r_rw && (r_addr == LO);
   assign lr_lo = !l_ce_n &&  l_rw && !l_oe_n && (l_addr == LO);

   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (l_int_n && r_int_n)); // R1
   AST_RIGHT_SET: assert property (@(posedge clk) disable iff (!rst_n) lw_hi |=> !r_int_n); // R2
   AST_RIGHT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rr_hi && !lw_hi) |=> r_int_n); // R3
   AST_LEFT_SET: assert property (@(posedge clk) disable iff (!rst_n) rw_lo |=> !l_int_n); // R4
   AST_LEFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (lr_lo && !rw_lo) |=> l_int_n); // R5
   AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!lw_hi && !rr_hi) |=> $stable(r_int_n)); // R9
   AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!rw_lo && !lr_lo) |=> $stable(l_int_n)); // R9

endmodule

bind mbx_irq_flags mbx_irq_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .l_ce_n  (l_ce_n),
   .l_rw    (l_rw),
   .l_oe_n  (l_oe_n),
   .l_addr  (l_addr),
   .r_ce_n  (r_ce_n),
   .r_rw    (r_rw),
   .r_oe_n  (r_oe_n),
   .r_addr  (r_addr),
   .l_int_n (l_int_n),
   .r_int_n (r_int_n)
);

// File: tb/mbx_irq_flags_tb.sv
module mbx_irq_flags_tb;

   localparam int unsigned AW = 12;
   localparam logic [AW-1:0] HI = 12'hFFF;
   localparam logic [AW-1:0] LO = 12'hFFE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_ce_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1;
   logic r_ce_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_int_n, r_int_n;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic exp_l = 1'b1, exp_r = 1'b1;

   always #10 clk = ~clk;

   mbx_irq_flags #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr),
      .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr),
      .l_int_n(l_int_n), .r_int_n(r_int_n)
   );

   function automatic logic f_wr(logic ce_n, logic rw, logic [AW-1:0] a, logic [AW-1:0] t);
      return !ce_n && !rw && (a == t);
   endfunction

   function automatic logic f_rd(logic ce_n, logic rw, logic oe_n, logic [AW-1:0] a, logic [AW-1:0] t);
      return !ce_n && rw && !oe_n && (a == t);
   endfunction

   function automatic logic f_next(logic cur, logic set, logic clr);
      return set ? 1'b0 : (clr ? 1'b1 : cur);
   endfunction

   task automatic check(string req);
      n_run++;
      if ({l_int_n, r_int_n} !== {exp_l, exp_r}) begin
         n_fail++;
         $display("FAIL %s: flags l/r actual %b%b expected %b%b", req, l_int_n, r_int_n, exp_l, exp_r);
      end
   endtask

   // Drive both ports on the falling edge, update the model at the rising edge, sample after it.
   task automatic cyc(logic lc, logic lr, logic lo, logic [AW-1:0] la,
                      logic rc, logic rr, logic ro, logic [AW-1:0] ra, string req);
      @(negedge clk);
      l_ce_n = lc; l_rw = lr; l_oe_n = lo; l_addr = la;
      r_ce_n = rc; r_rw = rr; r_oe_n = ro; r_addr = ra;
      @(posedge clk);
      exp_r = f_next(exp_r, f_wr(lc, lr, la, HI), f_rd(rc, rr, ro, ra, HI));
      exp_l = f_next(exp_l, f_wr(rc, rr, ra, LO), f_rd(lc, lr, lo, la, LO));
      #5;
      check(req);
   endtask

   task automatic idle(string req);
      cyc(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, 1'b1, '0, req);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      check("R1 reset state");
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1 after release");

      // Left -> right mailbox
      cyc(0, 0, 1, HI, 1, 1, 1, '0, "R2 left write top sets right flag");
      cyc(0, 1, 0, HI, 1, 1, 1, '0, "R8 left read of top ignored");
      cyc(1, 1, 1, '0, 0, 1, 1, HI, "R7 right read top without oe ignored");
      cyc(1, 1, 1, '0, 1, 1, 0, HI, "R7 right read top without ce ignored");
      cyc(1, 1, 1, '0, 0, 1, 0, HI, "R3 right read top clears right flag");

      // Right -> left mailbox
      cyc(1, 1, 1, '0, 0, 0, 0, LO, "R4 right write next sets left flag (oe low)");
      cyc(1, 1, 1, '0, 0, 0, 1, HI, "R8 right write top ignored");
      cyc(0, 0, 1, LO, 1, 1, 1, '0, "R8 left write next ignored");
      cyc(1, 1, 1, '0, 0, 1, 0, LO, "R8 right read next ignored");
      cyc(0, 1, 0, 12'hFFD, 0, 0, 1, 12'h7FF, "R8 other addresses ignored");
      cyc(0, 1, 1, LO, 1, 1, 1, '0, "R7 left read next without oe ignored");
      cyc(0, 1, 0, LO, 1, 1, 1, '0, "R5 left read next clears left flag");
      cyc(1, 0, 1, HI, 1, 0, 1, LO, "R7 writes without ce ignored");

      // Same-edge set and clear
      cyc(0, 0, 1, HI, 0, 1, 0, HI, "R6 right set wins over clear");
      cyc(0, 1, 0, LO, 0, 0, 1, LO, "R6 left set wins over clear");
      repeat (3) idle("R9 flags hold");

      // Reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      exp_l = 1'b1; exp_r = 1'b1;
      #5;
      check("R1 asynchronous reset");
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1 after second release");

      // Constrained random
      void'($urandom(32'd1357));
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] la, ra;
         la = ($urandom_range(0, 3) != 0) ? (HI - AW'($urandom_range(0, 2))) : AW'($urandom);
         ra = ($urandom_range(0, 3) != 0) ? (HI - AW'($urandom_range(0, 2))) : AW'($urandom);
         cyc(($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, la,
             ($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, ra,
             "R9 random mix");
      end

      finish_run();
   end

endmodule